// File: doc/BRIEF.md
# CAN FD Interrupt Status Unit

This block gathers the interrupt causes of a CAN FD controller into one 12-bit status word and drives a single interrupt line. It takes three kinds of cause:

- **One-cycle event strobes.** These cover frame received, frame transmitted, arbitration lost, bus error, overload frame, receive buffer full and bit rate switched.
- **Transitions it detects itself.** These are crossings of the error warning limit by the transmit and receive error counters, changes of the fault confinement state, and hardware commands that move a transmit buffer into a final state.
- **Levels.** These are the data overrun flag and the receive buffer "not empty" condition.

A small register port gives software access. Address 0 reads the status word, and writing ones to it clears bits. Address 1 reads and writes an enable mask. A cause whose mask bit is zero never sets its status bit, so the interrupt line stays low for it. The interrupt line is high whenever any status bit is set.

Two kinds of cause are not simple latches.

- **Warning limit.** The warning-limit cause fires when the counters cross the limit in either direction. It does not fire again while the counters stay on the same side of the limit.
- **Level causes.** The overrun and not-empty causes keep setting their bits for as long as their condition holds, so a clear does not remove them until the cause is gone.

Top module: `can_irq_status`

## Requirements
- R1: After reset, the status word and the mask are all zeros, and `irqOut` is low.
- R2: `rdData` shows the status word when `rdAddr`=0 and the mask when `rdAddr`=1.
  - A write to address 0 clears each status bit where `wrData` has a one and leaves bits with a zero unchanged.
  - A write to address 1 loads the mask. A mask bit of 1 enables its cause.
- R3: Event strobe `evtStb[k]` sets a status bit one clock after it is sampled, using this map:
  - `evtStb[0]` sets bit 0 (frame received).
  - `evtStb[1]` sets bit 1 (frame transmitted).
  - `evtStb[2]` sets bit 5 (arbitration lost).
  - `evtStb[3]` sets bit 6 (bus error).
  - `evtStb[4]` sets bit 7 (overload).
  - `evtStb[5]` sets bit 8 (receive buffer full).
  - `evtStb[6]` sets bit 9 (bit rate switched).
- R4: A cause whose mask bit is 0 does not set its status bit. `irqOut` is high exactly when at least one status bit is set.
- R5: When a cause sets a bit in the same cycle that a write clears it, the bit ends up set.
- R6: Bit 2 sets when both error counters were below `warnLimit` and at least one becomes greater than or equal to it.
- R7: Bit 2 also sets when both counters drop below `warnLimit` after at least one was at or above it. Bit 2 does not set again while the counters remain on the same side of the limit.
- R8: Bit 4 sets on fault state changes active→passive, passive→bus-off, bus-off→active and passive→active.
  - The fault state encoding is 00 active, 01 passive, 10 bus-off.
  - Changes active→bus-off and bus-off→passive do not set bit 4.
- R9: Bit 3 follows the data overrun flag as a level. While the flag is high, a clear leaves bit 3 set.
- R10: Bit 10 is set while `rxEmpty` is low. A clear while the buffer still holds data leaves bit 10 set.
- R11: Bit 11 sets when any transmit buffer `i` has `txCmdValid[i]` high and a nonzero code in `txCmdCode[2i+1:2i]`.
  - The codes are 01 TX OK, 10 error and 11 aborted.
  - Code 00 does not set bit 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evtStb | input | 7 | One-cycle event strobes (map in R3) |
| txErrCnt | input | CNT_W | Transmit error counter |
| rxErrCnt | input | CNT_W | Receive error counter |
| warnLimit | input | CNT_W | Error warning limit |
| faultState | input | 2 | Fault confinement state (00 active, 01 passive, 10 bus-off) |
| overrunFlag | input | 1 | Data overrun flag (level) |
| rxEmpty | input | 1 | Receive buffer empty (level) |
| txCmdValid | input | NUM_TXBUF | Per-buffer hardware command strobe |
| txCmdCode | input | 2*NUM_TXBUF | Per-buffer command code |
| wrEn | input | 1 | Register write enable |
| wrAddr | input | 1 | Write address: 0 status (write-one-clear), 1 mask |
| wrData | input | 12 | Write data |
| rdAddr | input | 1 | Read address: 0 status, 1 mask |
| rdData | output | 12 | Read data |
| irqOut | output | 1 | Interrupt request |

## Verification
The assertions assume the following about the inputs:

- Each event strobe and transmit command lasts a single cycle per event.
- The fault state never takes the reserved code 11.

The overrun and not-empty checks also assume that a level held for a cycle counts as a fresh cause on every cycle.

The stimulus keeps within these assumptions in several ways. It drives every strobe for exactly one clock, and moves the fault state only among the three legal codes. It holds the counters steady between crossings, so that each warning-limit edge shows up as one observable transition.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;
  localparam int STAT_W = 12;
  localparam int EVT_W  = 7;

  // status bit positions
  localparam int B_RX     = 0;
  localparam int B_TX     = 1;
  localparam int B_WARN   = 2;
  localparam int B_OVR    = 3;
  localparam int B_FAULT  = 4;
  localparam int B_ARB    = 5;
  localparam int B_BUSERR = 6;
  localparam int B_OVLD   = 7;
  localparam int B_RXFULL = 8;
  localparam int B_RATE   = 9;
  localparam int B_RXNE   = 10;
  localparam int B_TXCMD  = 11;

  // event strobe lane positions
  localparam int E_RX     = 0;
  localparam int E_TX     = 1;
  localparam int E_ARB    = 2;
  localparam int E_BUSERR = 3;
  localparam int E_OVLD   = 4;
  localparam int E_RXFULL = 5;
  localparam int E_RATE   = 6;

  typedef enum logic [1:0] {
    FC_ACTIVE  = 2'b00,
    FC_PASSIVE = 2'b01,
    FC_BUSOFF  = 2'b10,
    FC_RSVD    = 2'b11
  } faultState_e;

  typedef enum logic [1:0] {
    TXC_NONE  = 2'b00,
    TXC_OK    = 2'b01,
    TXC_ERR   = 2'b10,
    TXC_ABORT = 2'b11
  } txCmd_e;

  typedef struct packed {
    logic [STAT_W-1:0] setReq;
    logic [STAT_W-1:0] clrReq;
    logic              maskWr;
    logic [STAT_W-1:0] maskData;
  } irqStrobe_t;
endpackage

// File: rtl/can_irq_ctrl.sv
module can_irq_ctrl
  import can_irq_pkg::*;
#(
  parameter int CNT_W     = 9,
  parameter int NUM_TXBUF = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [EVT_W-1:0]       evtStb,
  input  logic [CNT_W-1:0]       txErrCnt,
  input  logic [CNT_W-1:0]       rxErrCnt,
  input  logic [CNT_W-1:0]       warnLimit,
  input  logic [1:0]             faultState,
  input  logic                   overrunFlag,
  input  logic                   rxEmpty,
  input  logic [NUM_TXBUF-1:0]   txCmdValid,
  input  logic [2*NUM_TXBUF-1:0] txCmdCode,
  input  logic                   wrEn,
  input  logic                   wrAddr,
  input  logic [STAT_W-1:0]      wrData,
  output irqStrobe_t             strobe
);
  // warning-limit side tracker
  logic aboveNow;
  logic aboveQ;
  logic warnEvt;

  assign aboveNow = (txErrCnt >= warnLimit) || (rxErrCnt >= warnLimit);
  assign warnEvt  = aboveNow ^ aboveQ;

  always_ff @(posedge clk) begin
    if (!rstN) aboveQ <= 1'b0;
    else       aboveQ <= aboveNow;
  end

  // fault confinement transition detector
  faultState_e faultNow;
  faultState_e faultPrevQ;
  logic        faultEvt;

  assign faultNow = faultState_e'(faultState);

  always_ff @(posedge clk) begin
    if (!rstN) faultPrevQ <= FC_ACTIVE;
    else       faultPrevQ <= faultNow;
  end

  always_comb begin
    faultEvt = 1'b0;
    unique case ({faultPrevQ, faultNow})
      {FC_ACTIVE,  FC_PASSIVE}: faultEvt = 1'b1;
      {FC_PASSIVE, FC_BUSOFF }: faultEvt = 1'b1;
      {FC_BUSOFF,  FC_ACTIVE }: faultEvt = 1'b1;
      {FC_PASSIVE, FC_ACTIVE }: faultEvt = 1'b1;
      default:                  faultEvt = 1'b0;
    endcase
  end

  // transmit buffer final-state commands
  logic [NUM_TXBUF-1:0] bufHit;
  logic                 txCmdEvt;

  for (genvar i = 0; i < NUM_TXBUF; i++) begin : g_txbuf
    txCmd_e code;
    assign code      = txCmd_e'(txCmdCode[2*i +: 2]);
    assign bufHit[i] = txCmdValid[i] && (code != TXC_NONE);
  end

  assign txCmdEvt = |bufHit;

  // strobe assembly
  always_comb begin
    strobe.setReq           = '0;
    strobe.setReq[B_RX]     = evtStb[E_RX];
    strobe.setReq[B_TX]     = evtStb[E_TX];
    strobe.setReq[B_WARN]   = warnEvt;
    strobe.setReq[B_OVR]    = overrunFlag;
    strobe.setReq[B_FAULT]  = faultEvt;
    strobe.setReq[B_ARB]    = evtStb[E_ARB];
    strobe.setReq[B_BUSERR] = evtStb[E_BUSERR];
    strobe.setReq[B_OVLD]   = evtStb[E_OVLD];
    strobe.setReq[B_RXFULL] = evtStb[E_RXFULL];
    strobe.setReq[B_RATE]   = evtStb[E_RATE];
    strobe.setReq[B_RXNE]   = !rxEmpty;
    strobe.setReq[B_TXCMD]  = txCmdEvt;
    strobe.clrReq           = (wrEn && !wrAddr) ? wrData : '0;
    strobe.maskWr           = wrEn && wrAddr;
    strobe.maskData         = wrData;
  end
endmodule

// File: rtl/can_irq_dpath.sv
module can_irq_dpath
  import can_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  irqStrobe_t        strobe,
  input  logic              rdAddr,
  output logic [STAT_W-1:0] rdData,
  output logic [STAT_W-1:0] statusQ,
  output logic [STAT_W-1:0] maskQ,
  output logic              irqOut
);
  logic [STAT_W-1:0] statusD;

  // a set in the same cycle as a clear keeps the bit
  assign statusD = (statusQ & ~strobe.clrReq) | (strobe.setReq & maskQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ <= '0;
      maskQ   <= '0;
    end else begin
      statusQ <= statusD;
      if (strobe.maskWr) maskQ <= strobe.maskData;
    end
  end

  assign rdData = rdAddr ? maskQ : statusQ;
  assign irqOut = |statusQ;
endmodule

// File: rtl/can_irq_status.sv
module can_irq_status
  import can_irq_pkg::*;
#(
  parameter int CNT_W     = 9,
  parameter int NUM_TXBUF = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [6:0]             evtStb,
  input  logic [CNT_W-1:0]       txErrCnt,
  input  logic [CNT_W-1:0]       rxErrCnt,
  input  logic [CNT_W-1:0]       warnLimit,
  input  logic [1:0]             faultState,
  input  logic                   overrunFlag,
  input  logic                   rxEmpty,
  input  logic [NUM_TXBUF-1:0]   txCmdValid,
  input  logic [2*NUM_TXBUF-1:0] txCmdCode,
  input  logic                   wrEn,
  input  logic                   wrAddr,
  input  logic [11:0]            wrData,
  input  logic                   rdAddr,
  output logic [11:0]            rdData,
  output logic                   irqOut
);
  irqStrobe_t        strobe;
  logic [STAT_W-1:0] statusQ;
  logic [STAT_W-1:0] maskQ;

  can_irq_ctrl #(.CNT_W(CNT_W), .NUM_TXBUF(NUM_TXBUF)) u_ctrl (
    .clk(clk), .rstN(rstN), .evtStb(evtStb),
    .txErrCnt(txErrCnt), .rxErrCnt(rxErrCnt), .warnLimit(warnLimit),
    .faultState(faultState), .overrunFlag(overrunFlag), .rxEmpty(rxEmpty),
    .txCmdValid(txCmdValid), .txCmdCode(txCmdCode),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .strobe(strobe)
  );

  can_irq_dpath u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rdAddr(rdAddr),
    .rdData(rdData), .statusQ(statusQ), .maskQ(maskQ), .irqOut(irqOut)
  );
endmodule

// File: rtl/can_irq_checker.sv
module can_irq_checker #(
  parameter int NUM_TXBUF = 4
) (
  input logic                   clk,
  input logic                   rstN,
  input logic [6:0]             evtStb,
  input logic                   overrunFlag,
  input logic                   rxEmpty,
  input logic [NUM_TXBUF-1:0]   txCmdValid,
  input logic [2*NUM_TXBUF-1:0] txCmdCode,
  input logic                   wrEn,
  input logic                   wrAddr,
  input logic [11:0]            wrData,
  input logic [11:0]            statusQ,
  input logic [11:0]            maskQ,
  input logic                   irqOut
);
  AST_RX_STROBE_SETS: assert property (@(posedge clk) disable iff (!rstN)
    (evtStb[0] && maskQ[0]) |=> statusQ[0]);  // R3

  AST_MASKED_STAYS_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((statusQ & $past(~maskQ & ~statusQ)) == 12'h000));  // R4

  AST_IRQ_LOW_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (statusQ == 12'h000) |-> !irqOut);  // R4

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrAddr && wrData[1] && !evtStb[1]) |=> !statusQ[1]);  // R2

  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrAddr && wrData[0] && evtStb[0] && maskQ[0]) |=> statusQ[0]);  // R5

  AST_OVERRUN_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    (overrunFlag && maskQ[3]) |=> statusQ[3]);  // R9

  AST_RXNE_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    (!rxEmpty && maskQ[10]) |=> statusQ[10]);  // R10

  AST_TXCMD_SETS: assert property (@(posedge clk) disable iff (!rstN)
    (txCmdValid[0] && (txCmdCode[1:0] != 2'b00) && maskQ[11]) |=> statusQ[11]);  // R11
endmodule

bind can_irq_status can_irq_checker #(.NUM_TXBUF(NUM_TXBUF)) u_chk (
  .clk(clk), .rstN(rstN), .evtStb(evtStb), .overrunFlag(overrunFlag),
  .rxEmpty(rxEmpty), .txCmdValid(txCmdValid), .txCmdCode(txCmdCode),
  .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .statusQ(statusQ), .maskQ(maskQ), .irqOut(irqOut)
);

// File: tb/tb_can_irq_status.sv
`timescale 1ns/1ps
module tb_can_irq_status;
  localparam int CNT_W     = 9;
  localparam int NUM_TXBUF = 4;

  logic                   clk = 1'b0;
  logic                   rstN;
  logic [6:0]             evtStb;
  logic [CNT_W-1:0]       txErrCnt, rxErrCnt, warnLimit;
  logic [1:0]             faultState;
  logic                   overrunFlag, rxEmpty;
  logic [NUM_TXBUF-1:0]   txCmdValid;
  logic [2*NUM_TXBUF-1:0] txCmdCode;
  logic                   wrEn, wrAddr, rdAddr;
  logic [11:0]            wrData, rdData;
  logic                   irqOut;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  can_irq_status #(.CNT_W(CNT_W), .NUM_TXBUF(NUM_TXBUF)) dut (
    .clk(clk), .rstN(rstN), .evtStb(evtStb), .txErrCnt(txErrCnt),
    .rxErrCnt(rxErrCnt), .warnLimit(warnLimit), .faultState(faultState),
    .overrunFlag(overrunFlag), .rxEmpty(rxEmpty), .txCmdValid(txCmdValid),
    .txCmdCode(txCmdCode), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .irqOut(irqOut)
  );

  // {evtStb, expected status} per R3 map
  localparam logic [18:0] VEC [9] = '{
    {7'b0000001, 12'h001},
    {7'b0000010, 12'h002},
    {7'b0000100, 12'h020},
    {7'b0001000, 12'h040},
    {7'b0010000, 12'h080},
    {7'b0100000, 12'h100},
    {7'b1000000, 12'h200},
    {7'b1111111, 12'h3E3},
    {7'b0100101, 12'h121}
  };

  task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic readStat(output logic [11:0] v);
    rdAddr = 1'b0; #1; v = rdData;
  endtask

  task automatic regWrite(input logic addr, input logic [11:0] d);
    wrEn = 1'b1; wrAddr = addr; wrData = d;
    cyc();
    wrEn = 1'b0; wrAddr = 1'b0; wrData = '0;
  endtask

  task automatic pulseEvt(input logic [6:0] e);
    evtStb = e; cyc(); evtStb = '0;
  endtask

  task automatic chkBit(input string req, input int b, input logic exp);
    logic [11:0] v;
    readStat(v);
    chk(req, {11'b0, v[b]}, {11'b0, exp});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [11:0] v;
    rstN = 1'b0; evtStb = '0; txErrCnt = '0; rxErrCnt = '0; warnLimit = 9'd96;
    faultState = 2'b00; overrunFlag = 1'b0; rxEmpty = 1'b1;
    txCmdValid = '0; txCmdCode = '0; wrEn = 1'b0; wrAddr = 1'b0;
    wrData = '0; rdAddr = 1'b0;
    repeat (3) cyc();
    rstN = 1'b1;
    cyc();

    // R1 reset state
    readStat(v); chk("R1 status", v, 12'h000);
    chk("R1 irq", {11'b0, irqOut}, 12'h000);
    rdAddr = 1'b1; #1; chk("R1 mask", rdData, 12'h000); rdAddr = 1'b0;

    // R4 with everything masked, a strobe sets nothing
    pulseEvt(7'h7F);
    readStat(v); chk("R4 all masked", v, 12'h000);

    // R2 mask write and readback
    regWrite(1'b1, 12'hFFF);
    rdAddr = 1'b1; #1; chk("R2 mask read", rdData, 12'hFFF); rdAddr = 1'b0;

    // R3 vector table
    foreach (VEC[i]) begin
      pulseEvt(VEC[i][18:12]);
      readStat(v); chk("R3 event map", v, VEC[i][11:0]);
      chk("R4 irq high", {11'b0, irqOut}, 12'h001);
      regWrite(1'b0, 12'hFFF);
      readStat(v); chk("R2 clear all", v, 12'h000);
      chk("R4 irq low", {11'b0, irqOut}, 12'h000);
    end

    // R2 writing zeros leaves bits alone
    pulseEvt(7'b0000011);
    regWrite(1'b0, 12'h001);
    readStat(v); chk("R2 partial clear", v, 12'h002);
    regWrite(1'b0, 12'hFFF);

    // R5 set in the clear cycle wins
    pulseEvt(7'b0000001);
    evtStb = 7'b0000001; regWrite(1'b0, 12'h001); evtStb = '0;
    readStat(v); chk("R5 set wins", v, 12'h001);
    regWrite(1'b0, 12'hFFF);

    // R4 single masked bit
    regWrite(1'b1, 12'hFFE);
    pulseEvt(7'b0000001);
    readStat(v); chk("R4 masked rx", v, 12'h000);
    chk("R4 masked irq", {11'b0, irqOut}, 12'h000);
    regWrite(1'b1, 12'hFFF);

    // R6 / R7 warning limit
    txErrCnt = 9'd95; cyc(); chkBit("R6 below", 2, 1'b0);
    txErrCnt = 9'd96; cyc(); chkBit("R6 up crossing", 2, 1'b1);
    regWrite(1'b0, 12'h004); chkBit("R7 cleared", 2, 1'b0);
    rxErrCnt = 9'd120; cyc(); chkBit("R7 no retrigger", 2, 1'b0);
    txErrCnt = 9'd10;  cyc(); chkBit("R7 still above", 2, 1'b0);
    rxErrCnt = 9'd95;  cyc(); chkBit("R7 down crossing", 2, 1'b1);
    regWrite(1'b0, 12'h004);
    cyc(); chkBit("R7 stays clear below", 2, 1'b0);

    // R8 fault confinement
    faultState = 2'b01; cyc(); chkBit("R8 act->pas", 4, 1'b1); regWrite(1'b0, 12'h010);
    faultState = 2'b10; cyc(); chkBit("R8 pas->boff", 4, 1'b1); regWrite(1'b0, 12'h010);
    faultState = 2'b00; cyc(); chkBit("R8 boff->act", 4, 1'b1); regWrite(1'b0, 12'h010);
    faultState = 2'b10; cyc(); chkBit("R8 act->boff none", 4, 1'b0);
    faultState = 2'b01; cyc(); chkBit("R8 boff->pas none", 4, 1'b0);
    faultState = 2'b00; cyc(); chkBit("R8 pas->act", 4, 1'b1); regWrite(1'b0, 12'h010);

    // R9 overrun level
    overrunFlag = 1'b1; cyc(); chkBit("R9 set", 3, 1'b1);
    regWrite(1'b0, 12'h008); chkBit("R9 reassert", 3, 1'b1);
    overrunFlag = 1'b0; cyc(); regWrite(1'b0, 12'h008); chkBit("R9 gone", 3, 1'b0);

    // R10 receive not empty
    rxEmpty = 1'b0; cyc(); chkBit("R10 set", 10, 1'b1);
    regWrite(1'b0, 12'h400); chkBit("R10 reassert", 10, 1'b1);
    rxEmpty = 1'b1; cyc(); regWrite(1'b0, 12'h400); chkBit("R10 gone", 10, 1'b0);

    // R11 transmit buffer commands
    txCmdValid = 4'b0100; txCmdCode = 8'b00_00_00_00; cyc();
    txCmdValid = '0; chkBit("R11 code 00 ignored", 11, 1'b0);
    txCmdValid = 4'b0001; txCmdCode = 8'b00_00_00_01; cyc();
    txCmdValid = '0; chkBit("R11 tx ok", 11, 1'b1); regWrite(1'b0, 12'h800);
    txCmdValid = 4'b1000; txCmdCode = 8'b10_00_00_00; cyc();
    txCmdValid = '0; chkBit("R11 error", 11, 1'b1); regWrite(1'b0, 12'h800);
    txCmdValid = 4'b0010; txCmdCode = 8'b00_00_11_00; cyc();
    txCmdValid = '0; chkBit("R11 aborted", 11, 1'b1); regWrite(1'b0, 12'h800);

    readStat(v); chk("R4 final idle", v, 12'h000);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule